// File: doc/BRIEF.md
# Calibrated Timebase Divider

This block turns an oscillator enable (nominally 32768 pulses per second) into a one-second tick and a one-minute tick. Crystal error is corrected digitally, not by trimming the crystal. The first second of selected minutes is made shorter or longer by a fixed amount. Those minutes are chosen from a repeating 64-minute cycle, and a 5-bit step count decides how many of them are corrected. A sign bit decides whether the clock is sped up or slowed down.

A halt input freezes the whole chain. A frequency-test input brings out a square wave that is taken from its own divider, ahead of the correction. A trimming fixture can therefore measure the raw oscillator error, and the value programmed into the calibration word does not disturb that measurement.

The calibration word is captured while reset is high and again at each minute boundary. A new value therefore always applies to a whole minute. Sizes are parameters: `OSC_HZ` (enables per second), `CORR_UNIT` (size of the correction stage), `SEC_PER_MIN` and `TEST_HZ`.

Top module: `cal_timebase`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `sec_tick`, `min_tick` and `test_out` are 0. The calibration word is captured during reset.
- R2: With no correction active, `sec_tick` pulses for one cycle after every `OSC_HZ` clock cycles in which `osc_en`=1 and `halt`=0.
- R3: `min_tick` pulses in the same cycle as every `SEC_PER_MIN`-th `sec_tick` and at no other time.
- R4: With sign bit `cal_ctrl[5]`=1 and step count N=`cal_ctrl[4:0]`>0, the first second of every minute whose index in the 64-minute cycle is below 2N is shortened by `CORR_UNIT` enables.
- R5: With `cal_ctrl[5]`=0 and N>0, the first second of every minute whose index is below 2N is lengthened by `CORR_UNIT`/2 enables.
- R6: The minute index wraps from 63 to 0. Minutes with index of 2N or more are not altered, so N=31 alters 62 of the 64 minutes.
- R7: A change to `cal_ctrl` takes effect only from the next minute boundary.
- R8: While `halt`=1, no counter advances and no tick is issued. Counting resumes from the held state.
- R9: A cycle with `osc_en`=0 advances nothing and issues no tick.
- R10: With `ftest`=1 and `halt`=0, `test_out` is a square wave whose level changes every `OSC_HZ`/(2·`TEST_HZ`) enables (512 Hz by default). This holds whatever value `cal_ctrl` carries.
- R11: `test_out` is 0 one cycle after `ftest`=0 or `halt`=1 is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | One pulse per oscillator period |
| cal_ctrl | input | 6 | [5] speed-up sign, [4:0] step count |
| halt | input | 1 | Freezes the divider chain |
| ftest | input | 1 | Enables the test square wave |
| sec_tick | output | 1 | One-cycle pulse per second |
| min_tick | output | 1 | One-cycle pulse per minute |
| test_out | output | 1 | Uncorrected test square wave |

## Verification
Every output is registered. A tick is due exactly one clock after the enable that completes its second or minute. A level change of `test_out` is due one clock after the enable that ends a half period, and the forced-low state is due one clock after `ftest` or `halt` changes.

The bench drives inputs at the falling edge and samples at the next falling edge. It credits each sample to the enable applied before the rising edge just passed. Second lengths are therefore counted in applied enables, and a tick that arrives after an idle edge is reported. The bench runs small parameters so that full 64-minute cycles can be observed.

// File: rtl/caltb_pkg.sv
package caltb_pkg;
  localparam int CYCLE_MINUTES = 64;
  localparam int CYC_W = $clog2(CYCLE_MINUTES);

  typedef struct packed {
    logic       speed_up;
    logic [4:0] steps;
  } cal_word_t;
endpackage

// File: rtl/cal_minute_seq.sv
module cal_minute_seq
  import caltb_pkg::*;
#(
  parameter int SEC_PER_MIN = 60
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      sec_end,
  input  cal_word_t cal_in,
  output logic      min_end,
  output logic      shorten,
  output logic      stretch
);
  localparam int SW = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;

  logic [SW-1:0]    sec_idx;
  logic [CYC_W-1:0] min_idx;
  cal_word_t        cal_q;
  logic             in_window;
  logic             altered;

  assign min_end = sec_end && (sec_idx == SW'(SEC_PER_MIN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_idx <= '0;
      min_idx <= '0;
      cal_q   <= cal_in;
    end else if (sec_end) begin
      if (min_end) begin
        sec_idx <= '0;
        min_idx <= min_idx + 1'b1;
        cal_q   <= cal_in;
      end else begin
        sec_idx <= sec_idx + 1'b1;
      end
    end
  end

  // window of 2N minutes at the start of each cycle
  assign in_window = {1'b0, min_idx} < {cal_q.steps, 1'b0};
  assign altered   = in_window && (sec_idx == '0);
  assign shorten   = altered && cal_q.speed_up;
  assign stretch   = altered && !cal_q.speed_up;

  // R6: minute index steps by one and wraps modulo the cycle
  a_r6_cycle_step: assert property (@(posedge clk) disable iff (rst)
    min_end |=> (min_idx == $past(min_idx) + 1'b1));

  // R7: the captured calibration word only changes at a minute boundary
  a_r7_cal_hold: assert property (@(posedge clk) disable iff (rst)
    !min_end |=> $stable(cal_q));
endmodule

// File: rtl/sec_divider.sv
module sec_divider #(
  parameter int OSC_HZ    = 32768,
  parameter int CORR_UNIT = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic shorten,
  input  logic stretch,
  output logic sec_end,
  output logic sec_tick
);
  localparam int LONGEST = OSC_HZ + CORR_UNIT / 2;
  localparam int CW      = $clog2(LONGEST + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] len;

  always_comb begin
    if (shorten)      len = CW'(OSC_HZ - CORR_UNIT);
    else if (stretch) len = CW'(LONGEST);
    else              len = CW'(OSC_HZ);
  end

  assign sec_end = adv && (cnt == len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      sec_tick <= 1'b0;
    end else begin
      sec_tick <= sec_end;
      if (sec_end)  cnt <= '0;
      else if (adv) cnt <= cnt + 1'b1;
    end
  end

  // R8, R9: an idle edge never produces a tick
  a_r8_no_tick_idle: assert property (@(posedge clk) disable iff (rst)
    !adv |=> !sec_tick);

  // R2: the count never leaves the longest legal second
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(LONGEST));
endmodule

// File: rtl/test_tone.sv
module test_tone #(
  parameter int OSC_HZ  = 32768,
  parameter int TEST_HZ = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic ftest,
  input  logic halt,
  output logic test_out
);
  localparam int HALF = OSC_HZ / (2 * TEST_HZ);
  localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [HW-1:0] tcnt;
  logic          phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt     <= '0;
      phase    <= 1'b0;
      test_out <= 1'b0;
    end else begin
      if (adv) begin
        if (tcnt == HW'(HALF - 1)) begin
          tcnt  <= '0;
          phase <= ~phase;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
      test_out <= ftest && !halt && phase;
    end
  end

  // R11: test output is quiet after the test is off or the chain halted
  a_r11_quiet: assert property (@(posedge clk) disable iff (rst)
    (!ftest || halt) |=> !test_out);
endmodule

// File: rtl/cal_timebase.sv
module cal_timebase
  import caltb_pkg::*;
#(
  parameter int OSC_HZ      = 32768,
  parameter int CORR_UNIT   = 256,
  parameter int SEC_PER_MIN = 60,
  parameter int TEST_HZ     = 512
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       osc_en,
  input  logic [5:0] cal_ctrl,
  input  logic       halt,
  input  logic       ftest,
  output logic       sec_tick,
  output logic       min_tick,
  output logic       test_out
);
  logic      adv;
  logic      sec_end;
  logic      min_end;
  logic      shorten;
  logic      stretch;
  cal_word_t cal_in;

  assign adv    = osc_en && !halt;
  assign cal_in = cal_word_t'(cal_ctrl);

  sec_divider #(.OSC_HZ(OSC_HZ), .CORR_UNIT(CORR_UNIT)) u_div (
    .clk(clk), .rst(rst), .adv(adv), .shorten(shorten), .stretch(stretch),
    .sec_end(sec_end), .sec_tick(sec_tick)
  );

  cal_minute_seq #(.SEC_PER_MIN(SEC_PER_MIN)) u_seq (
    .clk(clk), .rst(rst), .sec_end(sec_end), .cal_in(cal_in),
    .min_end(min_end), .shorten(shorten), .stretch(stretch)
  );

  test_tone #(.OSC_HZ(OSC_HZ), .TEST_HZ(TEST_HZ)) u_tone (
    .clk(clk), .rst(rst), .adv(adv), .ftest(ftest), .halt(halt),
    .test_out(test_out)
  );

  always_ff @(posedge clk) begin
    if (rst) min_tick <= 1'b0;
    else     min_tick <= min_end;
  end

  // R3: a minute tick always coincides with a second tick
  a_r3_min_with_sec: assert property (@(posedge clk) disable iff (rst)
    min_tick |-> sec_tick);
endmodule

// File: tb/cal_timebase_test.sv
module cal_timebase_test;
  localparam int OSC   = 256;
  localparam int CU    = 32;
  localparam int SPM   = 2;
  localparam int THZ   = 32;
  localparam int HALFP = OSC / (2 * THZ);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic osc_en = 1'b0;
  logic [5:0] cal_ctrl = 6'd0;
  logic halt = 1'b0;
  logic ftest = 1'b0;
  logic sec_tick, min_tick, test_out;

  int n_chk = 0;
  int n_bad = 0;
  int acc = 0;
  int pend = 0;
  bit got = 0;
  int glen = 0;
  bit gmin = 0;
  int lens [0:255];
  bit mins [0:255];
  int cyc = 0;

  always #5 clk = ~clk;

  cal_timebase #(.OSC_HZ(OSC), .CORR_UNIT(CU), .SEC_PER_MIN(SPM), .TEST_HZ(THZ)) uut (
    .clk(clk), .rst(rst), .osc_en(osc_en), .cal_ctrl(cal_ctrl), .halt(halt),
    .ftest(ftest), .sec_tick(sec_tick), .min_tick(min_tick), .test_out(test_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic step(input logic en, input logic hl);
    got = 0;
    @(negedge clk);
    acc += pend;
    if (sec_tick) begin
      got = 1; glen = acc; gmin = min_tick; acc = 0;
      if (pend == 0) chk(0, "R8/R9 tick after idle edge", 1, 0);
    end else if (min_tick) begin
      chk(0, "R3 minute tick without second tick", 1, 0);
    end
    osc_en = en; halt = hl; pend = (en && !hl) ? 1 : 0;
  endtask

  task automatic do_reset(input logic [5:0] cw);
    rst = 1'b1; cal_ctrl = cw; ftest = 1'b0;
    repeat (3) step(1'b0, 1'b0);
    chk(!sec_tick && !min_tick && !test_out, "R1 outputs in reset",
        {sec_tick, min_tick, test_out}, 0);
    rst = 1'b0; acc = 0; pend = 0;
    step(1'b1, 1'b0);
    chk(!sec_tick && !min_tick && !test_out, "R1 outputs after release",
        {sec_tick, min_tick, test_out}, 0);
  endtask

  task automatic gather(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      int k = 0;
      do begin
        case (mode)
          1: step(logic'(k % 2), 1'b0);
          2: step(1'b1, logic'(k >= 100 && k < 200));
          default: step(1'b1, 1'b0);
        endcase
        k++;
      end while (!got && k < 3000);
      lens[i] = got ? glen : -1;
      mins[i] = gmin;
    end
  endtask

  task automatic t_plain;
    do_reset(6'd0);
    gather(4, 0);
    for (int i = 0; i < 4; i++) begin
      chk(lens[i] == OSC, "R2 uncorrected second length", lens[i], OSC);
      chk(mins[i] == (i % 2 == 1), "R3 minute tick placement", mins[i], i % 2);
    end
  endtask

  task automatic t_positive;
    do_reset(6'b100001);
    gather(6, 0);
    for (int i = 0; i < 6; i++) begin
      int e = (i == 0 || i == 2) ? OSC - CU : OSC;
      chk(lens[i] == e, "R4 positive step shortens", lens[i], e);
    end
  endtask

  task automatic t_negative;
    do_reset(6'b000010);
    gather(10, 0);
    for (int i = 0; i < 10; i++) begin
      int e = (i < 8 && i % 2 == 0) ? OSC + CU / 2 : OSC;
      chk(lens[i] == e, "R5 negative step lengthens", lens[i], e);
    end
  endtask

  task automatic t_full_cycle;
    int shorts = 0;
    do_reset(6'b111111);
    gather(130, 0);
    for (int i = 0; i < 128; i++) if (lens[i] == OSC - CU) shorts++;
    chk(shorts == 62, "R6 altered minutes per cycle", shorts, 62);
    for (int i = 124; i < 128; i++)
      chk(lens[i] == OSC, "R6 minutes 62 and 63 unaltered", lens[i], OSC);
    chk(lens[128] == OSC - CU, "R6 cycle wraps to minute 0", lens[128], OSC - CU);
  endtask

  task automatic t_late_change;
    do_reset(6'd0);
    gather(1, 0);
    cal_ctrl = 6'b111111;
    gather(3, 0);
    chk(lens[0] == OSC, "R7 rest of minute unchanged", lens[0], OSC);
    chk(lens[1] == OSC - CU, "R7 new word at next minute", lens[1], OSC - CU);
    chk(lens[2] == OSC, "R7 second 1 of minute unaltered", lens[2], OSC);
  endtask

  task automatic t_halt_gate;
    do_reset(6'd0);
    gather(2, 2);
    chk(lens[0] == OSC, "R8 halt holds count", lens[0], OSC);
    chk(lens[1] == OSC, "R8 resumes normally", lens[1], OSC);
    gather(2, 1);
    chk(lens[0] == OSC, "R9 gapped enable", lens[0], OSC);
    chk(lens[1] == OSC, "R9 gapped enable second 2", lens[1], OSC);
  endtask

  task automatic t_tone;
    int since;
    bit prev;
    bit seen;
    int bad_iv;
    do_reset(6'd0);
    for (int pass = 0; pass < 2; pass++) begin
      ftest = 1'b1;
      if (pass == 1) cal_ctrl = 6'b111111;
      since = 0; seen = 0; bad_iv = 0; prev = test_out;
      for (int k = 0; k < 40; k++) begin
        step(1'b1, 1'b0);
        since++;
        if (test_out != prev) begin
          if (seen && since != HALFP) bad_iv = since;
          seen = 1; since = 0; prev = test_out;
        end
      end
      chk(seen && bad_iv == 0, "R10 test half period", bad_iv, HALFP);
    end
    ftest = 1'b0;
    step(1'b1, 1'b0);
    for (int k = 0; k < 12; k++) begin
      step(1'b1, 1'b0);
      chk(!test_out, "R11 quiet when test off", test_out, 0);
    end
    ftest = 1'b1;
    step(1'b1, 1'b1);
    for (int k = 0; k < 12; k++) begin
      step(1'b1, 1'b1);
      chk(!test_out, "R11 quiet when halted", test_out, 0);
    end
    ftest = 1'b0;
  endtask

  initial begin
    t_plain;
    t_positive;
    t_negative;
    t_full_cycle;
    t_late_change;
    t_halt_gate;
    t_tone;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule